// File: doc/BRIEF.md
# Three-Channel Alarm Comparator With Periodic Re-Arm

This block watches two free-running 52-bit counters supplied from outside and raises interrupts when they reach programmed alarm points. It has three independent channels. Each channel picks one of the two counters and compares it against its own effective target. In one-shot mode the effective target is an absolute value, and the channel fires once. In periodic mode the channel sets its first target one period after the count at the moment the configuration is committed. After each match it moves the target forward by one period on its own.

Software programs a channel through a word-addressed write port. The target, period, mode and counter choice go into shadow registers. None of these writes has any effect until a commit word is written to that channel. The effective target in use can be read back at any time. A small interrupt bank holds a raw bit for each channel, a per-channel interrupt enable and a masked status view. These combine into a single interrupt line.

Top module: `alarm_cmp_top`

## Requirements
- R1: After synchronous reset, the raw, enable and status words read 0, `irq` is 0, every effective target reads 0, and no channel can fire until it has been committed.
- R2: A write to a channel's target-low (word 8+4c), target-high (word 9+4c, bits 19:0) or config (word 10+4c) changes only its shadow copy, which reads back at the same address. The effective target (read at words 32+2c low and 33+2c high) keeps its value until a commit word (word 11+4c) is written.
- R3: In one-shot mode (config bit 30 = 0), a commit sets the effective target to the 52-bit shadow target. The channel fires when the selected count is greater than or equal to that target, and it fires only once per commit.
- R4: In periodic mode (config bit 30 = 1), a commit sets the effective target to the selected count at the commit cycle plus the period in config bits 25:0. Each match adds the period again, carrying from the low word into the high word and wrapping modulo 2^52.
- R5: Config bit 31 selects the counter: 0 compares against `cnt_a`, 1 compares against `cnt_b`. The other counter has no effect on the channel.
- R6: Bit c of the work-enable word (word 0) gates channel c. While that bit is clear, the channel never sets its raw bit.
- R7: A match sets raw bit c (read at word 2) one clock edge after the compare holds. Writing 1 to bit c of word 3 clears raw bit c. When a match and a clear of the same bit meet in one cycle, the bit stays set.
- R8: The status word (word 4) equals raw AND interrupt-enable (word 1, bits 2:0). `irq` is the OR of the status bits and changes on the same edge as raw.
- R9: The effective-target high word returns the top 20 bits in bits 19:0 with zeros above. Read data is registered and appears one cycle after `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_a | input | 52 | First live counter value |
| cnt_b | input | 52 | Second live counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its defaults: three channels, 52-bit counters and a 26-bit period. With these values the carry from the low 32-bit word into the 20-bit high word falls inside reach, and it is driven on purpose with a periodic commit just below a 32-bit boundary. Random rounds choose the channel, mode, counter choice, distance to the target and interrupt mask. Directed cases cover a match landing on equality, a zero period that matches every cycle while a clear is being written, and a shadow write that has not been committed.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // word addresses of the common registers
  localparam int ADR_WORK_EN  = 0;
  localparam int ADR_INT_EN   = 1;
  localparam int ADR_RAW      = 2;
  localparam int ADR_CLR      = 3;
  localparam int ADR_STATUS   = 4;
  // per-channel window: 4 words each
  localparam int ADR_CH_BASE  = 8;
  localparam int CH_STRIDE    = 4;
  localparam int OFS_TLO      = 0;
  localparam int OFS_THI      = 1;
  localparam int OFS_CFG      = 2;
  localparam int OFS_COMMIT   = 3;
  // effective target readback: 2 words per channel
  localparam int ADR_EFF_BASE = 32;
  // config word bit positions
  localparam int CFG_MODE_BIT = 30;
  localparam int CFG_SEL_BIT  = 31;
endpackage

// File: rtl/alarm_chan.sv
module alarm_chan
  import alarm_pkg::*;
#(
  parameter int CNT_W = 52,
  parameter int PER_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_cfg,
  input  logic             commit,
  input  logic [31:0]      wr_data,
  input  logic             work_en,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             hit,
  output logic [CNT_W-1:0] eff,
  output logic [31:0]      sh_lo,
  output logic [31:0]      sh_hi,
  output logic [31:0]      sh_cfg
);
  localparam int HI_W = CNT_W - 32;

  // shadow copy, written by software
  logic [31:0]      tlo_q;
  logic [HI_W-1:0]  thi_q;
  logic [PER_W-1:0] per_sh_q;
  logic             mode_sh_q, sel_sh_q;
  // active copy, loaded on commit
  logic [PER_W-1:0] per_q;
  logic             mode_q, sel_q, armed_q;
  logic [CNT_W-1:0] eff_q;

  logic [CNT_W-1:0] cnt_now, cnt_cmt;
  logic             hit_c;

  assign cnt_now = sel_q    ? cnt_b : cnt_a;
  assign cnt_cmt = sel_sh_q ? cnt_b : cnt_a;
  assign hit_c   = armed_q && work_en && !commit && (cnt_now >= eff_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tlo_q     <= '0;
      thi_q     <= '0;
      per_sh_q  <= '0;
      mode_sh_q <= 1'b0;
      sel_sh_q  <= 1'b0;
      per_q     <= '0;
      mode_q    <= 1'b0;
      sel_q     <= 1'b0;
      armed_q   <= 1'b0;
      eff_q     <= '0;
    end else begin
      if (wr_lo) tlo_q <= wr_data;
      if (wr_hi) thi_q <= wr_data[HI_W-1:0];
      if (wr_cfg) begin
        per_sh_q  <= wr_data[PER_W-1:0];
        mode_sh_q <= wr_data[CFG_MODE_BIT];
        sel_sh_q  <= wr_data[CFG_SEL_BIT];
      end
      if (commit) begin
        per_q   <= per_sh_q;
        mode_q  <= mode_sh_q;
        sel_q   <= sel_sh_q;
        armed_q <= 1'b1;
        eff_q   <= mode_sh_q ? (cnt_cmt + CNT_W'(per_sh_q)) : {thi_q, tlo_q};
      end else if (hit_c) begin
        if (mode_q) eff_q   <= eff_q + CNT_W'(per_q);
        else        armed_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sh_cfg               = '0;
    sh_cfg[PER_W-1:0]    = per_sh_q;
    sh_cfg[CFG_MODE_BIT] = mode_sh_q;
    sh_cfg[CFG_SEL_BIT]  = sel_sh_q;
  end

  assign sh_lo = tlo_q;
  assign sh_hi = 32'(thi_q);
  assign hit   = hit_c;
  assign eff   = eff_q;

  // R3: an absolute commit loads the shadow target
  p_commit_abs_r3: assert property (@(posedge clk) disable iff (rst)
    commit && !mode_sh_q |=> eff_q == $past({thi_q, tlo_q}));
  // R3: a one-shot channel cannot fire on two consecutive cycles without a commit
  p_oneshot_once_r3: assert property (@(posedge clk) disable iff (rst)
    hit && !mode_q |=> !hit);
  // R4: a periodic match advances the target by exactly one period
  p_rearm_r4: assert property (@(posedge clk) disable iff (rst)
    hit && mode_q |=> (eff_q - $past(eff_q)) == CNT_W'($past(per_q)));
  // R6: a disabled channel never fires
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !work_en |-> !hit);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ena,
  input  logic              wr_clr,
  input  logic [NUM_CH-1:0] wr_bits,
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] ena,
  output logic              irq
);
  logic [NUM_CH-1:0] raw_q, ena_q, raw_n, ena_n, clr;
  logic              irq_q;

  assign clr   = wr_clr ? wr_bits : '0;
  assign raw_n = (raw_q & ~clr) | hit;   // set wins over clear
  assign ena_n = wr_ena ? wr_bits : ena_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      ena_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_n;
      ena_q <= ena_n;
      irq_q <= |(raw_n & ena_n);
    end
  end

  assign raw = raw_q;
  assign ena = ena_q;
  assign irq = irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7: a match always lands in the raw bit
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
      hit[c] |=> raw_q[c]);
    // R7: a clear without a match empties the raw bit
    p_clr_r7: assert property (@(posedge clk) disable iff (rst)
      wr_clr && wr_bits[c] && !hit[c] |=> !raw_q[c]);
  end
  // R8: the line tracks the masked raw bits
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(raw_q & ena_q));
endmodule

// File: rtl/alarm_rdmux.sv
module alarm_rdmux
  import alarm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 52,
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [NUM_CH-1:0]            work_en,
  input  logic [NUM_CH-1:0]            raw,
  input  logic [NUM_CH-1:0]            ena,
  input  logic [NUM_CH-1:0][CNT_W-1:0] eff,
  input  logic [NUM_CH-1:0][31:0]      sh_lo,
  input  logic [NUM_CH-1:0][31:0]      sh_hi,
  input  logic [NUM_CH-1:0][31:0]      sh_cfg,
  output logic [31:0]                  rd_data
);
  localparam int HI_W = CNT_W - 32;
  logic [31:0] rd_n, rd_q;

  always_comb begin
    rd_n = '0;
    if (rd_addr == ADDR_W'(ADR_WORK_EN)) rd_n = 32'(work_en);
    if (rd_addr == ADDR_W'(ADR_INT_EN))  rd_n = 32'(ena);
    if (rd_addr == ADDR_W'(ADR_RAW))     rd_n = 32'(raw);
    if (rd_addr == ADDR_W'(ADR_STATUS))  rd_n = 32'(raw & ena);
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(ADR_CH_BASE + CH_STRIDE*c + OFS_TLO)) rd_n = sh_lo[c];
      if (rd_addr == ADDR_W'(ADR_CH_BASE + CH_STRIDE*c + OFS_THI)) rd_n = sh_hi[c];
      if (rd_addr == ADDR_W'(ADR_CH_BASE + CH_STRIDE*c + OFS_CFG)) rd_n = sh_cfg[c];
      if (rd_addr == ADDR_W'(ADR_EFF_BASE + 2*c))     rd_n = eff[c][31:0];
      if (rd_addr == ADDR_W'(ADR_EFF_BASE + 2*c + 1)) rd_n = 32'(eff[c][CNT_W-1:32]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign rd_data = rd_q;

  // R9: the high readback word never shows bits above the counter width
  p_hi_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr) == ADDR_W'(ADR_EFF_BASE + 1) |-> rd_q[31:HI_W] == '0);
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 52,
  parameter int PER_W  = 26,
  parameter int ADDR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]      rd_data,
  output logic             irq
);
  logic [NUM_CH-1:0]            work_en_q, hit, raw, ena;
  logic [NUM_CH-1:0][CNT_W-1:0] eff;
  logic [NUM_CH-1:0][31:0]      sh_lo, sh_hi, sh_cfg;

  always_ff @(posedge clk) begin
    if (rst) work_en_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(ADR_WORK_EN)) work_en_q <= wr_data[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = ADR_CH_BASE + CH_STRIDE*c;
    logic wr_lo, wr_hi, wr_cfg, commit;
    assign wr_lo  = wr_en && wr_addr == ADDR_W'(BASE + OFS_TLO);
    assign wr_hi  = wr_en && wr_addr == ADDR_W'(BASE + OFS_THI);
    assign wr_cfg = wr_en && wr_addr == ADDR_W'(BASE + OFS_CFG);
    assign commit = wr_en && wr_addr == ADDR_W'(BASE + OFS_COMMIT);

    alarm_chan #(.CNT_W(CNT_W), .PER_W(PER_W)) i_chan (
      .clk(clk), .rst(rst),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_cfg(wr_cfg), .commit(commit),
      .wr_data(wr_data), .work_en(work_en_q[c]),
      .cnt_a(cnt_a), .cnt_b(cnt_b),
      .hit(hit[c]), .eff(eff[c]),
      .sh_lo(sh_lo[c]), .sh_hi(sh_hi[c]), .sh_cfg(sh_cfg[c])
    );
  end

  alarm_irq #(.NUM_CH(NUM_CH)) i_irq (
    .clk(clk), .rst(rst),
    .wr_ena(wr_en && wr_addr == ADDR_W'(ADR_INT_EN)),
    .wr_clr(wr_en && wr_addr == ADDR_W'(ADR_CLR)),
    .wr_bits(wr_data[NUM_CH-1:0]),
    .hit(hit), .raw(raw), .ena(ena), .irq(irq)
  );

  alarm_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_rdmux (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .work_en(work_en_q), .raw(raw), .ena(ena), .eff(eff),
    .sh_lo(sh_lo), .sh_hi(sh_hi), .sh_cfg(sh_cfg),
    .rd_data(rd_data)
  );

  // R1: nothing is pending straight after reset
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> raw == '0 && !irq);
endmodule

// File: tb/test_alarm_cmp_top.sv
module test_alarm_cmp_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 52;
  // register words as stated in the requirements
  localparam logic [5:0] A_WEN = 0, A_IEN = 1, A_RAW = 2, A_CLR = 3, A_ST = 4;

  logic clk = 0, rst = 1;
  logic [CW-1:0] cnt_a = '0, cnt_b = '0;
  logic wr_en = 0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_cmp_top i_alarm_cmp_top (
    .clk(clk), .rst(rst), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [5:0] a_tlo(int c); return 6'(8 + 4*c); endfunction
  function automatic logic [5:0] a_thi(int c); return 6'(9 + 4*c); endfunction
  function automatic logic [5:0] a_cfg(int c); return 6'(10 + 4*c); endfunction
  function automatic logic [5:0] a_cmt(int c); return 6'(11 + 4*c); endfunction
  function automatic logic [5:0] a_elo(int c); return 6'(32 + 2*c); endfunction
  function automatic logic [5:0] a_ehi(int c); return 6'(33 + 2*c); endfunction
  function automatic logic [31:0] cfg_word(int per, bit mode, bit sel);
    return {sel, mode, 4'b0, 26'(per)};
  endfunction
  function automatic logic [CW-1:0] periodic_target(logic [CW-1:0] base, int per);
    return base + CW'(per);
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic rd_eff(int c, output logic [CW-1:0] e);
    logic [31:0] lo, hi;
    rd(a_elo(c), lo); rd(a_ehi(c), hi);
    e = {hi[19:0], lo};
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] e, base, tgt;
    void'($urandom(32'h1a2b3c));
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    rd(A_RAW, v); chk("R1 raw", 64'(v), 0);
    rd(A_ST, v);  chk("R1 status", 64'(v), 0);
    rd_eff(0, e); chk("R1 eff0", 64'(e), 0);
    rd_eff(2, e); chk("R1 eff2", 64'(e), 0);

    // R2 shadow write without commit
    wr(a_tlo(2), 32'h1234);
    rd_eff(2, e); chk("R2 eff before commit", 64'(e), 0);
    rd(a_tlo(2), v); chk("R2 shadow readback", 64'(v), 64'h1234);
    wr(a_cmt(2), 1);
    rd_eff(2, e); chk("R2 eff after commit", 64'(e), 64'h1234);

    // R4/R9 periodic commit carries into high word
    cnt_a = 52'hFFFF_FFF0;
    wr(a_cfg(2), cfg_word(32'h20, 1, 0));
    wr(a_cmt(2), 1);
    rd(a_elo(2), v); chk("R4 carry low", 64'(v), 64'h10);
    rd(a_ehi(2), v); chk("R9 carry high", 64'(v), 64'h1);

    // R5 counter selection, R3 equality match
    cnt_a = 52'd1000; cnt_b = 52'd10;
    wr(a_tlo(1), 500); wr(a_thi(1), 0);
    wr(a_cfg(1), cfg_word(0, 0, 1));
    wr(a_cmt(1), 1);
    wr(A_WEN, 3'b010);
    idle(3);
    rd(A_RAW, v); chk("R5 unselected counter ignored", 64'(v), 0);
    @(negedge clk); cnt_b = 52'd500;
    idle(2);
    rd(A_RAW, v); chk("R3 match on equality", 64'(v), 64'b010);

    // R8 masking
    wr(A_IEN, 3'b010); idle(1);
    chk("R8 irq enabled", 64'(irq), 1);
    rd(A_ST, v); chk("R8 status", 64'(v), 64'b010);
    wr(A_IEN, 3'b000); idle(1);
    chk("R8 irq masked", 64'(irq), 0);
    rd(A_RAW, v); chk("R8 raw kept when masked", 64'(v), 64'b010);

    // R3 one shot per commit
    wr(A_CLR, 3'b010);
    idle(3);
    rd(A_RAW, v); chk("R3 no second fire", 64'(v), 0);
    wr(a_cmt(1), 1); idle(2);
    rd(A_RAW, v); chk("R3 recommit fires", 64'(v), 64'b010);
    wr(A_CLR, 3'b010);

    // R7 set wins over clear: periodic, zero period fires each cycle
    cnt_a = 52'd100;
    wr(a_cfg(0), cfg_word(0, 1, 0));
    wr(a_cmt(0), 1);
    wr(A_WEN, 3'b001);
    idle(2);
    wr(A_CLR, 3'b001);
    rd(A_RAW, v); chk("R7 set wins over clear", 64'(v), 64'b001);
    rd_eff(0, e); chk("R4 zero period keeps target", 64'(e), 64'd100);
    // R6 gating
    wr(A_WEN, 3'b000);
    wr(A_CLR, 3'b001);
    idle(3);
    rd(A_RAW, v); chk("R6 disabled channel silent", 64'(v), 0);

    // random rounds
    for (int it = 0; it < 40; it++) begin
      int ch, per;
      bit mode, sel;
      logic [2:0] ien;
      ch   = int'($urandom_range(0, 2));
      mode = 1'($urandom);
      sel  = 1'($urandom);
      per  = int'($urandom_range(1, 5000));
      ien  = 3'($urandom);
      base = {1'b0, 19'($urandom), 32'($urandom)};
      tgt  = base + CW'($urandom_range(1, 3000));
      wr(A_WEN, 0);
      wr(A_CLR, 3'b111);
      wr(A_IEN, {29'b0, ien});
      @(negedge clk);
      if (sel) begin cnt_b = base; cnt_a = {20'($urandom), 32'($urandom)}; end
      else     begin cnt_a = base; cnt_b = {20'($urandom), 32'($urandom)}; end
      wr(a_tlo(ch), tgt[31:0]);
      wr(a_thi(ch), 32'(tgt[51:32]));
      wr(a_cfg(ch), cfg_word(per, mode, sel));
      wr(a_cmt(ch), 1);
      if (mode) tgt = periodic_target(base, per);
      rd_eff(ch, e); chk(mode ? "R4 random commit" : "R3 random commit", 64'(e), 64'(tgt));
      wr(A_WEN, 32'(1 << ch));
      idle(2);
      rd(A_RAW, v); chk("R5 random no early fire", 64'(v), 0);
      @(negedge clk);
      if (sel) cnt_b = tgt + CW'(mode ? 0 : $urandom_range(0, 3));
      else     cnt_a = tgt + CW'(mode ? 0 : $urandom_range(0, 3));
      idle(2);
      rd(A_RAW, v); chk("R7 random raw set", 64'(v), 64'(1 << ch));
      chk("R8 random irq", 64'(irq), 64'(ien[ch]));
      rd_eff(ch, e);
      chk(mode ? "R4 random rearm" : "R3 random target held", 64'(e),
          64'(mode ? periodic_target(tgt, per) : tgt));
      wr(A_CLR, 32'(1 << ch));
      idle(2);
      rd(A_RAW, v); chk("R7 random clear", 64'(v), 0);
      chk("R8 random irq low", 64'(irq), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule